// File: doc/BRIEF.md
# TDM Serial Audio Port

This block joins a time-division-multiplexed serial audio bus as one of several devices that share it. An external master supplies the bit clock and a frame sync pulse one bit clock wide. The frame sync repeats at the sample rate. Each frame is divided into a configurable number of equal slots, and this port owns one of them. In its own slot the port shifts out a parallel sample word, most significant bit first, and captures the word that arrives on the receive line. Outside that slot it releases the transmit line through an output-enable, so other devices can drive it.

All bus inputs are oversampled by the system clock through synchronizers. The port supports two alignments of data against the sync pulse. In the late alignment, the frame's first bit follows the sync period. In the early alignment, the first bit coincides with the sync period. A free-running bit counter predicts where the next sync should arrive. A sync pulse at any other position realigns the counter and raises a one-cycle error strobe. Software-side access is a valid/ready handshake for transmit words and a one-cycle strobe for received words.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is high and in the cycle after it is released, `txd_oe_o`, `rx_valid_o` and `frame_err_o` are 0 and `tx_ready_o` is 1.
- R2: With `mode_b_i`=1, the bit-clock period in which the frame sync is sampled high is bit 0 of the frame. The MSB of slot 0 is driven during that same period.
- R3: With `mode_b_i`=0, the period in which the frame sync is sampled high is the last bit of the frame. The MSB of slot 0 is driven in the following period.
- R4: `txd_o` and `txd_oe_o` change only after a falling bit-clock edge. `rxd_i` is sampled at rising bit-clock edges.
- R5: `width_sel_i` encodes the slot width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. `slot_cnt_m1_i` holds the slot count minus one (1 to 8 slots). Slot k occupies frame bits k*W to k*W+W-1, MSB first.
- R6: `txd_oe_o` is 1 exactly during the bit periods of slot `slot_sel_i` and 0 otherwise. `txd_o` is 0 whenever `txd_oe_o` is 0. If `slot_sel_i` is not below the slot count, the port never drives.
- R7: `tx_ready_o` is 1 while the one-word holding register is empty. A word is taken on a cycle with `tx_valid_i` and `tx_ready_o` both high. The word is consumed at the start of the assigned slot, and its low W bits are sent MSB first.
- R8: If no word is held when the assigned slot starts, the slot is still driven, with all-zero data.
- R9: After the last bit of the assigned slot, the W received bits appear MSB-aligned to bit W-1 of `rx_data_o`, zero-extended, with a one-cycle `rx_valid_o`. Bits in other slots never affect `rx_data_o`.
- R10: A frame sync sampled after lock at a position other than the expected one gives a one-cycle `frame_err_o` and restarts the frame count from that sync.
- R11: Before the first frame sync is seen, the port neither drives the bus nor reports received words. A slot counts only if its bit 0 occurs after lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock from the bus master |
| fsync_i | input | 1 | Frame sync pulse, one bit clock wide |
| rxd_i | input | 1 | Serial receive data |
| mode_b_i | input | 1 | 1: first bit coincides with sync; 0: first bit follows sync |
| width_sel_i | input | 2 | Slot width code (R5) |
| slot_cnt_m1_i | input | 3 | Slots per frame minus one |
| slot_sel_i | input | 3 | Index of the slot this port owns |
| tx_data_i | input | 32 | Transmit sample word |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Holding register empty |
| txd_o | output | 1 | Serial transmit data |
| txd_oe_o | output | 1 | Transmit drive enable; bus released when 0 |
| rx_data_o | output | 32 | Received sample word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received word |
| frame_err_o | output | 1 | One-cycle strobe on a misplaced sync |

## Verification
A misplaced sync pulse is judged at the same bit-clock edge that may also capture bit 0 of the restarted frame. Error detection and realignment therefore happen together with the first receive and transmit decisions of the new frame. The bench provokes this in the early alignment by cutting a frame short after five bits and then starting a full frame with a sync. It expects exactly one error strobe. The transmit word and the receive word of that very frame must both be correct.

// File: rtl/pcm_tdm_pkg.sv
`timescale 1ns/1ps
package pcm_tdm_pkg;

  // log2 of slot width for a width code: 8, 16, 32 bits
  function automatic logic [2:0] width_log2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd3;
      2'd1:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
`timescale 1ns/1ps
module pcm_edge_sync #(
  parameter int STAGES = 2,
  parameter int NSIG   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSIG-1:0] async_i,
  output logic [NSIG-1:0] sync_o,
  output logic            rise_o,
  output logic            fall_o
);
  // bit 0 of async_i is the bit clock; edges are detected on it
  logic [STAGES-1:0][NSIG-1:0] stg_q;
  logic                        clk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q      <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      stg_q[0] <= async_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      clk_prev_q <= stg_q[STAGES-1][0];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1][0] & ~clk_prev_q;
  assign fall_o = ~stg_q[STAGES-1][0] & clk_prev_q;
endmodule

// File: rtl/pcm_frame_ctr.sv
`timescale 1ns/1ps
module pcm_frame_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             fsync_i,
  input  logic             mode_b_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             locked_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_q, expect_idx, sync_idx;
  logic             locked_q, err_q;

  // index of the bit period being sampled now if nothing is wrong
  assign expect_idx = (cnt_q == len_m1_i) ? '0 : cnt_q + 1'b1;
  // index that a sync pulse marks for the selected alignment
  assign sync_idx   = mode_b_i ? '0 : len_m1_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (rise_i) begin
        if (fsync_i) begin
          cnt_q    <= sync_idx;
          locked_q <= 1'b1;
          if (locked_q && (expect_idx != sync_idx)) err_q <= 1'b1;
        end else begin
          cnt_q <= expect_idx;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign locked_o = locked_q;
  assign err_o    = err_q;
endmodule

// File: rtl/pcm_slot_dec.sv
`timescale 1ns/1ps
module pcm_slot_dec #(
  parameter int CNT_W  = 8,
  parameter int SLOT_W = 3
) (
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [2:0]        wlog_i,
  input  logic [SLOT_W-1:0] sel_i,
  output logic              hit_o,
  output logic              first_o,
  output logic              last_o
);
  logic [CNT_W-1:0] bit_mask, slot_num, bit_pos;

  assign bit_mask = CNT_W'((32'd1 << wlog_i) - 32'd1);
  assign slot_num = idx_i >> wlog_i;
  assign bit_pos  = idx_i & bit_mask;
  assign hit_o    = (slot_num == CNT_W'(sel_i));
  assign first_o  = (bit_pos == '0);
  assign last_o   = (bit_pos == bit_mask);
endmodule

// File: rtl/pcm_tx_ser.sv
`timescale 1ns/1ps
module pcm_tx_ser #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_i,
  input  logic              locked_i,
  input  logic              hit_i,
  input  logic              first_i,
  input  logic [2:0]        wlog_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] hold_q, sh_q, src, load_word;
  logic              full_q, act_q, txd_q, oe_q;

  assign src       = full_q ? hold_q : '0;
  assign load_word = src << (DATA_W - (32'd1 << wlog_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full_q <= 1'b0;
      sh_q   <= '0;
      act_q  <= 1'b0;
      txd_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (valid_i && !full_q) begin
        hold_q <= data_i;
        full_q <= 1'b1;
      end
      if (fall_i) begin
        if (locked_i && hit_i && first_i) begin
          sh_q  <= load_word;
          txd_q <= load_word[DATA_W-1];
          oe_q  <= 1'b1;
          act_q <= 1'b1;
          if (full_q) full_q <= 1'b0;
        end else if (locked_i && hit_i && act_q) begin
          sh_q  <= sh_q << 1;
          txd_q <= sh_q[DATA_W-2];
          oe_q  <= 1'b1;
        end else begin
          txd_q <= 1'b0;
          oe_q  <= 1'b0;
          act_q <= 1'b0;
        end
      end
    end
  end

  assign ready_o = ~full_q;
  assign txd_o   = txd_q;
  assign oe_o    = oe_q;
endmodule

// File: rtl/pcm_rx_des.sv
`timescale 1ns/1ps
module pcm_rx_des #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              bit_i,
  input  logic              locked_i,
  input  logic              hit_i,
  input  logic              first_i,
  input  logic              last_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] sh_q, data_q, shifted;
  logic              armed_q, valid_q;

  assign shifted = {sh_q[DATA_W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      data_q  <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (evt_i) begin
        if (locked_i && hit_i && first_i) begin
          sh_q    <= {{(DATA_W-1){1'b0}}, bit_i};
          armed_q <= 1'b1;
        end else if (locked_i && hit_i && armed_q) begin
          sh_q <= shifted;
          if (last_i) begin
            data_q  <= shifted;
            valid_q <= 1'b1;
            armed_q <= 1'b0;
          end
        end else begin
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/pcm_tdm_port.sv
`timescale 1ns/1ps
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SLOT_IDX_W  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bclk_i,
  input  logic                  fsync_i,
  input  logic                  rxd_i,
  input  logic                  mode_b_i,
  input  logic [1:0]            width_sel_i,
  input  logic [SLOT_IDX_W-1:0] slot_cnt_m1_i,
  input  logic [SLOT_IDX_W-1:0] slot_sel_i,
  input  logic [DATA_W-1:0]     tx_data_i,
  input  logic                  tx_valid_i,
  output logic                  tx_ready_o,
  output logic                  txd_o,
  output logic                  txd_oe_o,
  output logic [DATA_W-1:0]     rx_data_o,
  output logic                  rx_valid_o,
  output logic                  frame_err_o
);
  localparam int MAX_SLOTS = 1 << SLOT_IDX_W;
  localparam int CNT_W     = $clog2(DATA_W * MAX_SLOTS);

  logic [2:0]       sync_vec;
  logic             rise_evt, fall_evt, fsync_s, rxd_s;
  logic [2:0]       wlog;
  logic [CNT_W:0]   len_full;
  logic [CNT_W-1:0] len_m1, cnt_q, nxt_idx;
  logic             locked;
  logic             tx_hit, tx_first, tx_last;
  logic             rx_hit, rx_first, rx_last;
  logic             rx_evt_q, rx_bit_q;

  pcm_edge_sync #(.STAGES(SYNC_STAGES), .NSIG(3)) u_sync (
    .clk(clk), .rst(rst), .async_i({rxd_i, fsync_i, bclk_i}),
    .sync_o(sync_vec), .rise_o(rise_evt), .fall_o(fall_evt)
  );
  assign fsync_s = sync_vec[1];
  assign rxd_s   = sync_vec[2];

  assign wlog     = width_log2(width_sel_i);
  assign len_full = ((CNT_W+1)'(slot_cnt_m1_i) + (CNT_W+1)'(1)) << wlog;
  assign len_m1   = CNT_W'(len_full - (CNT_W+1)'(1));

  pcm_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .rise_i(rise_evt), .fsync_i(fsync_s),
    .mode_b_i(mode_b_i), .len_m1_i(len_m1),
    .cnt_o(cnt_q), .locked_o(locked), .err_o(frame_err_o)
  );

  // transmit decides at a falling edge for the coming bit period
  assign nxt_idx = (cnt_q == len_m1) ? '0 : cnt_q + 1'b1;

  pcm_slot_dec #(.CNT_W(CNT_W), .SLOT_W(SLOT_IDX_W)) u_dec_tx (
    .idx_i(nxt_idx), .wlog_i(wlog), .sel_i(slot_sel_i),
    .hit_o(tx_hit), .first_o(tx_first), .last_o(tx_last)
  );

  pcm_slot_dec #(.CNT_W(CNT_W), .SLOT_W(SLOT_IDX_W)) u_dec_rx (
    .idx_i(cnt_q), .wlog_i(wlog), .sel_i(slot_sel_i),
    .hit_o(rx_hit), .first_o(rx_first), .last_o(rx_last)
  );

  // receive acts one cycle after the rising edge, once the count is updated
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_evt_q <= 1'b0;
      rx_bit_q <= 1'b0;
    end else begin
      rx_evt_q <= rise_evt;
      if (rise_evt) rx_bit_q <= rxd_s;
    end
  end

  pcm_tx_ser #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .fall_i(fall_evt), .locked_i(locked),
    .hit_i(tx_hit), .first_i(tx_first), .wlog_i(wlog),
    .data_i(tx_data_i), .valid_i(tx_valid_i), .ready_o(tx_ready_o),
    .txd_o(txd_o), .oe_o(txd_oe_o)
  );

  pcm_rx_des #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .evt_i(rx_evt_q), .bit_i(rx_bit_q),
    .locked_i(locked), .hit_i(rx_hit), .first_i(rx_first), .last_i(rx_last),
    .data_o(rx_data_o), .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/pcm_tdm_port_chk.sv
`timescale 1ns/1ps
module pcm_tdm_port_chk (
  input logic clk,
  input logic rst,
  input logic fall_evt,
  input logic rise_evt,
  input logic fsync_s,
  input logic locked,
  input logic txd_o,
  input logic txd_oe_o,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic frame_err_o
);
  // R1: outputs idle right after reset release
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!txd_oe_o && !rx_valid_o && !frame_err_o && tx_ready_o));

  // R4: transmit pins only move after a falling bit-clock edge
  a_r4_tx_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$stable(txd_o) || !$stable(txd_oe_o)) |-> $past(fall_evt));

  // R6: released line carries zero
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !txd_oe_o |-> !txd_o);

  // R7: an accepted word fills the holding register
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R9: receive strobe is a single cycle
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  // R10: error strobe is one cycle and follows a sampled sync
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);
  a_r10_err_after_sync: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> $past(rise_evt && fsync_s));

  // R11: no drive before lock
  a_r11_no_drive_unlocked: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !txd_oe_o);
endmodule

bind pcm_tdm_port pcm_tdm_port_chk u_chk (
  .clk(clk), .rst(rst), .fall_evt(fall_evt), .rise_evt(rise_evt),
  .fsync_s(fsync_s), .locked(locked), .txd_o(txd_o), .txd_oe_o(txd_oe_o),
  .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
  .rx_valid_o(rx_valid_o), .frame_err_o(frame_err_o)
);

// File: tb/pcm_tdm_port_bench.sv
`timescale 1ns/1ps
module pcm_tdm_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_i = 1'b0, fsync_i = 1'b0, rxd_i = 1'b0;
  logic        mode_b_i = 1'b0;
  logic [1:0]  width_sel_i = 2'd0;
  logic [2:0]  slot_cnt_m1_i = 3'd0, slot_sel_i = 3'd0;
  logic [31:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        tx_ready_o, txd_o, txd_oe_o, rx_valid_o, frame_err_o;
  logic [31:0] rx_data_o;

  int n_chk = 0, n_bad = 0, err_seen = 0;
  bit done = 0;
  logic [31:0] rxq[$];
  bit cfg_mb;
  int cfg_w, cfg_ns, cfg_slot;

  always #2.5 clk = ~clk;

  pcm_tdm_port u_pcm_tdm_port (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .fsync_i(fsync_i), .rxd_i(rxd_i),
    .mode_b_i(mode_b_i), .width_sel_i(width_sel_i), .slot_cnt_m1_i(slot_cnt_m1_i),
    .slot_sel_i(slot_sel_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .txd_o(txd_o), .txd_oe_o(txd_oe_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .frame_err_o(frame_err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each received word, counts error strobes
  always @(negedge clk) begin : mon
    logic [31:0] e;
    if (!rst) begin
      if (rx_valid_o) begin
        if (rxq.size() == 0) chk(1'b0, "R9 unexpected rx word", rx_data_o, '0);
        else begin
          e = rxq.pop_front();
          chk(rx_data_o == e, "R9 rx word", rx_data_o, e);
        end
      end
      if (frame_err_o) err_seen++;
    end
  end

  task automatic setup(input bit mb, input int wsel, input int ns, input int slot);
    cfg_mb = mb; cfg_w = 8 << wsel; cfg_ns = ns; cfg_slot = slot;
    @(negedge clk);
    rst = 1'b1; bclk_i = 1'b0; fsync_i = 1'b0; rxd_i = 1'b0; tx_valid_i = 1'b0;
    mode_b_i = mb; width_sel_i = 2'(wsel); slot_cnt_m1_i = 3'(ns - 1); slot_sel_i = 3'(slot);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rxq.delete();
    err_seen = 0;
  endtask

  task automatic push_tx(input logic [31:0] w);
    @(negedge clk);
    chk(tx_ready_o == 1'b1, "R7 ready before offer", 32'(tx_ready_o), 32'd1);
    tx_data_i = w; tx_valid_i = 1'b1;
    @(negedge clk);
    tx_valid_i = 1'b0;
    chk(tx_ready_o == 1'b0, "R7 ready drops after accept", 32'(tx_ready_o), 32'd0);
  endtask

  // driver: one frame (or nper bit periods of it); pushes expected rx word
  task automatic do_frame(input int nper, input logic [31:0] rxw, input logic [31:0] txexp,
                          input bit chk_tx, input bit drive_exp, input bit push_rx,
                          input string tag);
    int W, L, oe_bad, stab_bad;
    logic [31:0] mask, got;
    logic lo_txd;
    W = cfg_w; L = cfg_w * cfg_ns;
    mask = (W == 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);
    got = '0; oe_bad = 0; stab_bad = 0;
    if (push_rx) rxq.push_back(rxw & mask);
    for (int p = 0; p < nper; p++) begin
      int s, b;
      logic e_oe;
      s = p / W; b = p % W;
      @(negedge clk);
      bclk_i  = 1'b0;
      fsync_i = cfg_mb ? (p == 0) : (p == L - 1);
      rxd_i   = (s == cfg_slot) ? rxw[W-1-b] : ~rxw[W-1-b];
      repeat (8) @(negedge clk);
      e_oe = drive_exp && (s == cfg_slot);
      if (txd_oe_o !== e_oe) oe_bad++;
      if (s == cfg_slot) got = {got[30:0], txd_o};
      lo_txd = txd_o;
      bclk_i = 1'b1;
      repeat (7) @(negedge clk);
      if (txd_o !== lo_txd) stab_bad++;
    end
    if (chk_tx) begin
      chk(oe_bad == 0, "R6 drive window", 32'(oe_bad), 32'd0);
      chk(stab_bad == 0, "R4 tx held through rising edge", 32'(stab_bad), 32'd0);
      if (drive_exp) chk(got == (txexp & mask), tag, got, txexp & mask);
    end
  endtask

  initial begin
    // R1: reset state
    setup(1'b1, 0, 4, 0);
    chk(txd_oe_o == 1'b0, "R1 oe idle", 32'(txd_oe_o), 32'd0);
    chk(rx_valid_o == 1'b0, "R1 rx_valid idle", 32'(rx_valid_o), 32'd0);
    chk(tx_ready_o == 1'b1, "R1 ready after reset", 32'(tx_ready_o), 32'd1);
    chk(frame_err_o == 1'b0, "R1 no error", 32'(frame_err_o), 32'd0);

    // R2/R5: early alignment, 8-bit slots, 4 slots, own slot 0
    do_frame(32, 32'h0000_005A, '0, 1'b0, 1'b0, 1'b1, "warm");
    push_tx(32'hFFFF_FFC3);
    do_frame(32, 32'h0000_00A7, 32'h0000_00C3, 1'b1, 1'b1, 1'b1, "R2 MSB with sync, slot 0 word");
    chk(tx_ready_o == 1'b1, "R7 ready after slot consumed", 32'(tx_ready_o), 32'd1);
    push_tx(32'h0000_0081);
    do_frame(32, 32'h0000_0013, 32'h0000_0081, 1'b1, 1'b1, 1'b1, "R5 8-bit slot word");
    chk(rxq.size() == 0, "R9 all rx words seen", 32'(rxq.size()), 32'd0);
    chk(err_seen == 0, "R10 no false error", 32'(err_seen), 32'd0);

    // R3/R11: late alignment, 16-bit slots, 3 slots, own slot 2
    setup(1'b0, 1, 3, 2);
    do_frame(48, 32'h0000_1234, '0, 1'b1, 1'b0, 1'b0, "R11 warm");
    chk(rxq.size() == 0 && n_bad == 0, "R11 nothing before lock", 32'(rxq.size()), 32'd0);
    push_tx(32'h0000_B00C);
    do_frame(48, 32'h0000_F00D, 32'h0000_B00C, 1'b1, 1'b1, 1'b1, "R3 MSB after sync, 16-bit word");
    push_tx(32'h0000_8001);
    do_frame(48, 32'h0000_7FFE, 32'h0000_8001, 1'b1, 1'b1, 1'b1, "R3 second frame word");
    chk(rxq.size() == 0, "R9 16-bit rx words seen", 32'(rxq.size()), 32'd0);

    // R8: early alignment, 32-bit slots, 2 slots, own slot 1, then underrun
    setup(1'b1, 2, 2, 1);
    do_frame(64, 32'hCAFE_F00D, '0, 1'b0, 1'b0, 1'b1, "warm");
    push_tx(32'hDEAD_BEEF);
    do_frame(64, 32'h8765_4321, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, "R5 32-bit slot word");
    do_frame(64, 32'h0F0F_0F0F, 32'h0000_0000, 1'b1, 1'b1, 1'b1, "R8 underrun sends zeros");
    chk(tx_ready_o == 1'b1, "R8 ready stays high", 32'(tx_ready_o), 32'd1);
    chk(rxq.size() == 0, "R9 32-bit rx words seen", 32'(rxq.size()), 32'd0);

    // R6: own slot beyond slot count never drives, never receives
    setup(1'b0, 0, 4, 5);
    do_frame(32, 32'h0000_00FF, '0, 1'b1, 1'b0, 1'b0, "warm");
    do_frame(32, 32'h0000_00FF, '0, 1'b1, 1'b0, 1'b0, "R6 out of range");
    chk(rx_valid_o == 1'b0, "R6 no rx for absent slot", 32'(rx_valid_o), 32'd0);

    // R5: eight slots, own slot 7
    setup(1'b1, 0, 8, 7);
    do_frame(64, 32'h0000_0066, '0, 1'b0, 1'b0, 1'b1, "warm");
    push_tx(32'h0000_0099);
    do_frame(64, 32'h0000_00E1, 32'h0000_0099, 1'b1, 1'b1, 1'b1, "R5 last of eight slots");
    chk(rxq.size() == 0, "R9 slot 7 rx seen", 32'(rxq.size()), 32'd0);

    // R10: misplaced sync realigns and flags once
    setup(1'b1, 0, 2, 1);
    do_frame(16, 32'h0000_0011, '0, 1'b0, 1'b0, 1'b1, "warm");
    chk(err_seen == 0, "R10 no error on first lock", 32'(err_seen), 32'd0);
    push_tx(32'h0000_006C);
    do_frame(5, 32'h0000_0022, '0, 1'b0, 1'b0, 1'b0, "cut");
    do_frame(16, 32'h0000_00B4, 32'h0000_006C, 1'b1, 1'b1, 1'b1, "R10 frame after resync");
    chk(err_seen == 1, "R10 one error strobe", 32'(err_seen), 32'd1);
    push_tx(32'h0000_0035);
    do_frame(16, 32'h0000_004B, 32'h0000_0035, 1'b1, 1'b1, 1'b1, "R10 steady after resync");
    chk(err_seen == 1, "R10 no further error", 32'(err_seen), 32'd1);
    chk(rxq.size() == 0, "R9 rx after resync seen", 32'(rxq.size()), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule